// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block executes controller commands for a bank of hot-plug slots. A single command byte either drives one slot or all slots at once, or selects a secondary bus speed. For a slot command, the byte carries three 2-bit fields: a requested slot state, a power indicator value and an attention indicator value. A separate target byte names the slot, counting from 1. The engine checks each request and refuses any that is not allowed. It updates the per-slot status fields and reports the outcome through sticky command-status flags and a command-detected flag.

Each slot stores the following status:
- its state
- its two indicator fields
- a retention-latch-open bit
- a 2-bit presence code
- three event latches

A slot that drops to disabled while its power indicator reads off is treated as removed. Its latch reads open, its presence reads empty, and its button, latch and presence events are latched. Software clears the latched events per slot and the command-detected flag through dedicated clear inputs. While reset is held, the per-slot occupancy strap is sampled to build the starting status.

Top module: `hp_slot_cmd_engine`

## Requirements
- R1: While `rst_n` is low, a slot whose `occupied` strap is 1 loads state 2 (enabled), power indicator 1 (on), latch closed and presence 0. Otherwise the slot loads state 3 (disabled), power indicator 3 (off), latch open and presence 3 (empty). For every slot, attention is 0, the events are 0 and all flags are 0.
- R2: Command codes 0x00–0x3F are slot commands, decoded as state = bits [1:0], power = bits [3:2] and attention = bits [5:4]. The state encoding is 0 none, 1 power-only, 2 enabled, 3 disabled. A disabled slot moves to power-only or to enabled when asked. The result is visible on the clock edge that samples `cmd_wr`.
- R3: A request for power-only on an enabled slot sets `inv_cmd` and leaves all of that slot's fields unchanged, including both indicators.
- R4: An indicator field of 0 keeps the current indicator. Any value from 1 to 3 (on, blink, off) is written.
- R5: A target (`cmd_target[4:0]`) of 0, or one above NSLOTS, sets `inv_cmd` and changes no slot.
- R6: An enabled or power-only slot asked for disabled becomes disabled. If its power indicator (after this command's update) reads 3, the slot also gets `mrl_open`=1 and presence 3, and event bits [2:0] = button, latch, presence are all set.
- R7: Codes 0x40–0x47 are speed commands. Speed 0 (code 0x40) is accepted. Codes 0x41–0x47 set `inv_mode`.
- R8: Code 0x48 (all power-only) and code 0x49 (all enable) set `inv_cmd` and change nothing if any slot is enabled. Otherwise every slot with the latch closed gets the target state with the power indicator on, and every slot with the latch open gets state none with the power indicator off. Attention is left unchanged.
- R9: Codes 0x4A–0xFF set `inv_cmd`.
- R10: Each command first clears `inv_cmd` and `inv_mode`, and always sets `cmd_det`. `busy` reads 0 at all times.
- R11: `evt_clr[i]` clears slot i's events and `det_clr` clears `cmd_det`. An event or detect set by a command in the same cycle wins over the clear.
- R12: Any other requested transition, such as enabled to enabled or power-only to enabled, leaves the slot state unchanged and raises no flag. With no command, slot status holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| occupied | input | NSLOTS | Per-slot occupancy strap, sampled in reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_code | input | 8 | Command code |
| cmd_target | input | 8 | Target slot number, low 5 bits used |
| evt_clr | input | NSLOTS | Clear the event latches of a slot |
| det_clr | input | 1 | Clear command-detected |
| slot_state | output | 2*NSLOTS | Slot state per slot |
| pwr_led | output | 2*NSLOTS | Power indicator per slot |
| attn_led | output | 2*NSLOTS | Attention indicator per slot |
| presence | output | 2*NSLOTS | Presence code per slot |
| mrl_open | output | NSLOTS | Retention latch open per slot |
| slot_evt | output | 3*NSLOTS | Events per slot: [2] button, [1] latch, [0] presence |
| busy | output | 1 | Command busy, always 0 |
| inv_cmd | output | 1 | Invalid command flag |
| inv_mode | output | 1 | Invalid speed mode flag |
| cmd_det | output | 1 | Command detected flag |

## Verification
Two pairs of functions can collide in a single cycle. A removal command may latch a slot's events while software raises `evt_clr` for that same slot. Likewise, a command may set `cmd_det` in the cycle that `det_clr` is high. The bench provokes both collisions in directed steps and also injects random clears alongside random commands. Its model applies the clear first and the command's set second, so a passing result requires the set to win.

// File: rtl/hp_slot_cmd_engine.sv
module hp_slot_cmd_engine #(
  parameter int NSLOTS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSLOTS-1:0]     occupied,
  input  logic                  cmd_wr,
  input  logic [7:0]            cmd_code,
  input  logic [7:0]            cmd_target,
  input  logic [NSLOTS-1:0]     evt_clr,
  input  logic                  det_clr,
  output logic [2*NSLOTS-1:0]   slot_state,
  output logic [2*NSLOTS-1:0]   pwr_led,
  output logic [2*NSLOTS-1:0]   attn_led,
  output logic [2*NSLOTS-1:0]   presence,
  output logic [NSLOTS-1:0]     mrl_open,
  output logic [3*NSLOTS-1:0]   slot_evt,
  output logic                  busy,
  output logic                  inv_cmd,
  output logic                  inv_mode,
  output logic                  cmd_det
);
  localparam logic [1:0] ST_PWR = 2'd1, ST_EN = 2'd2, ST_DIS = 2'd3;
  localparam logic [1:0] LED_ON = 2'd1, LED_OFF = 2'd3;

  logic [1:0] st_q [NSLOTS];
  logic [1:0] pw_q [NSLOTS];
  logic [1:0] at_q [NSLOTS];
  logic [1:0] pr_q [NSLOTS];
  logic [2:0] ev_q [NSLOTS];
  logic [NSLOTS-1:0] mrl_q;

  logic [1:0] st_n [NSLOTS];
  logic [1:0] pw_n [NSLOTS];
  logic [1:0] at_n [NSLOTS];
  logic [1:0] rs [NSLOTS];
  logic [1:0] rp [NSLOTS];
  logic [1:0] ra [NSLOTS];
  logic [NSLOTS-1:0] sel, gone;

  logic [4:0] tgt;
  logic is_slot, is_spd, is_pall, is_all, tgt_ok, any_en, refuse, bad_cmd, bad_mode;

  assign tgt     = cmd_target[4:0];
  assign is_slot = cmd_code[7:6] == 2'b00;
  assign is_spd  = cmd_code[7:3] == 5'b01000;
  assign is_pall = cmd_code == 8'h48;
  assign is_all  = is_pall || cmd_code == 8'h49;
  assign tgt_ok  = tgt != 5'd0 && int'(tgt) <= NSLOTS;
  assign bad_cmd = (is_slot && (!tgt_ok || refuse)) || (is_all && any_en) ||
                   !(is_slot || is_spd || is_all);
  assign bad_mode = is_spd && cmd_code[2:0] != 3'd0;
  assign busy = 1'b0;

  always_comb begin
    any_en = 1'b0;
    refuse = 1'b0;
    for (int i = 0; i < NSLOTS; i++) begin
      if (st_q[i] == ST_EN) any_en = 1'b1;
      if (i + 1 == int'(tgt) && st_q[i] == ST_EN && cmd_code[1:0] == ST_PWR) refuse = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NSLOTS; i++) begin
      sel[i] = 1'b0;
      rs[i] = cmd_code[1:0];
      rp[i] = cmd_code[3:2];
      ra[i] = cmd_code[5:4];
      if (cmd_wr && is_slot && tgt_ok && !refuse && i + 1 == int'(tgt)) sel[i] = 1'b1;
      if (cmd_wr && is_all && !any_en) begin
        sel[i] = 1'b1;
        ra[i] = 2'd0;
        if (mrl_q[i]) begin
          rs[i] = 2'd0;
          rp[i] = LED_OFF;
        end else begin
          rs[i] = is_pall ? ST_PWR : ST_EN;
          rp[i] = LED_ON;
        end
      end
      pw_n[i] = (sel[i] && rp[i] != 2'd0) ? rp[i] : pw_q[i];
      at_n[i] = (sel[i] && ra[i] != 2'd0) ? ra[i] : at_q[i];
      st_n[i] = st_q[i];
      gone[i] = 1'b0;
      if (sel[i] && st_q[i] == ST_DIS && (rs[i] == ST_PWR || rs[i] == ST_EN))
        st_n[i] = rs[i];
      if (sel[i] && (st_q[i] == ST_EN || st_q[i] == ST_PWR) && rs[i] == ST_DIS) begin
        st_n[i] = ST_DIS;
        gone[i] = pw_n[i] == LED_OFF;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) begin
        st_q[i]  <= occupied[i] ? ST_EN : ST_DIS;
        pw_q[i]  <= occupied[i] ? LED_ON : LED_OFF;
        at_q[i]  <= 2'd0;
        pr_q[i]  <= occupied[i] ? 2'd0 : 2'd3;
        mrl_q[i] <= !occupied[i];
        ev_q[i]  <= 3'd0;
      end
      inv_cmd  <= 1'b0;
      inv_mode <= 1'b0;
      cmd_det  <= 1'b0;
    end else begin
      for (int i = 0; i < NSLOTS; i++) begin
        st_q[i] <= st_n[i];
        pw_q[i] <= pw_n[i];
        at_q[i] <= at_n[i];
        if (gone[i]) begin
          mrl_q[i] <= 1'b1;
          pr_q[i]  <= 2'd3;
        end
        ev_q[i] <= (evt_clr[i] ? 3'd0 : ev_q[i]) | {3{gone[i]}};
      end
      if (cmd_wr) begin
        inv_cmd  <= bad_cmd;
        inv_mode <= bad_mode;
        cmd_det  <= 1'b1;
      end else if (det_clr) begin
        cmd_det <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NSLOTS; g++) begin : g_out
    assign slot_state[2*g +: 2] = st_q[g];
    assign pwr_led[2*g +: 2]    = pw_q[g];
    assign attn_led[2*g +: 2]   = at_q[g];
    assign presence[2*g +: 2]   = pr_q[g];
    assign mrl_open[g]          = mrl_q[g];
    assign slot_evt[3*g +: 3]   = ev_q[g];
  end
endmodule

// File: rtl/hp_slot_cmd_engine_chk.sv
module hp_slot_cmd_engine_chk #(
  parameter int NSLOTS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_wr,
  input logic [7:0]          cmd_code,
  input logic [7:0]          cmd_target,
  input logic [2*NSLOTS-1:0] slot_state,
  input logic [2*NSLOTS-1:0] pwr_led,
  input logic [2*NSLOTS-1:0] attn_led,
  input logic [2*NSLOTS-1:0] presence,
  input logic [NSLOTS-1:0]   mrl_open,
  input logic [3*NSLOTS-1:0] slot_evt,
  input logic                inv_cmd,
  input logic                inv_mode,
  input logic                cmd_det
);
  AST_DET_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_det); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_cmd && inv_mode)); // R10
  AST_BAD_SPEED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_code[7:3] == 5'b01000 && cmd_code[2:0] != 3'd0 |=> inv_mode && !inv_cmd); // R7
  AST_UNDEF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_code > 8'h49 |=> inv_cmd && !inv_mode); // R9
  AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_code < 8'h40 && cmd_target[4:0] == 5'd0
    |=> inv_cmd && $stable(slot_state) && $stable(pwr_led) && $stable(attn_led)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(slot_state) && $stable(pwr_led) && $stable(attn_led)
    && $stable(presence) && $stable(mrl_open)); // R12
  AST_EVT_NO_SPONT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (slot_evt & ~$past(slot_evt)) == '0); // R11
  AST_MRL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mrl_open & $past(mrl_open)) == $past(mrl_open)); // R6
endmodule

bind hp_slot_cmd_engine hp_slot_cmd_engine_chk #(.NSLOTS(NSLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
  .cmd_target(cmd_target), .slot_state(slot_state), .pwr_led(pwr_led),
  .attn_led(attn_led), .presence(presence), .mrl_open(mrl_open),
  .slot_evt(slot_evt), .inv_cmd(inv_cmd), .inv_mode(inv_mode), .cmd_det(cmd_det)
);

// File: tb/hp_slot_cmd_engine_tb_top.sv
module hp_slot_cmd_engine_tb_top;
  localparam int N = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] occupied = '0, evt_clr = '0;
  logic cmd_wr = 1'b0, det_clr = 1'b0;
  logic [7:0] cmd_code = '0, cmd_target = '0;
  logic [2*N-1:0] slot_state, pwr_led, attn_led, presence;
  logic [N-1:0] mrl_open;
  logic [3*N-1:0] slot_evt;
  logic busy, inv_cmd, inv_mode, cmd_det;

  always #4 clk = ~clk;

  hp_slot_cmd_engine #(.NSLOTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .occupied(occupied), .cmd_wr(cmd_wr),
    .cmd_code(cmd_code), .cmd_target(cmd_target), .evt_clr(evt_clr),
    .det_clr(det_clr), .slot_state(slot_state), .pwr_led(pwr_led),
    .attn_led(attn_led), .presence(presence), .mrl_open(mrl_open),
    .slot_evt(slot_evt), .busy(busy), .inv_cmd(inv_cmd), .inv_mode(inv_mode),
    .cmd_det(cmd_det));

  int errs = 0, checks = 0;
  bit done = 0;
  logic [1:0] m_st [N];
  logic [1:0] m_pw [N];
  logic [1:0] m_at [N];
  logic [1:0] m_pr [N];
  logic [2:0] m_ev [N];
  logic m_mrl [N];
  logic m_ic, m_im, m_det;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [2*N-1:0] e_st, e_pw, e_at, e_pr;
    logic [N-1:0] e_mrl;
    logic [3*N-1:0] e_ev;
    for (int i = 0; i < N; i++) begin
      e_st[2*i +: 2] = m_st[i]; e_pw[2*i +: 2] = m_pw[i];
      e_at[2*i +: 2] = m_at[i]; e_pr[2*i +: 2] = m_pr[i];
      e_mrl[i] = m_mrl[i];      e_ev[3*i +: 3] = m_ev[i];
    end
    chk(tag, "state", 32'(slot_state), 32'(e_st));
    chk(tag, "pwr", 32'(pwr_led), 32'(e_pw));
    chk(tag, "attn", 32'(attn_led), 32'(e_at));
    chk(tag, "presence", 32'(presence), 32'(e_pr));
    chk(tag, "mrl", 32'(mrl_open), 32'(e_mrl));
    chk(tag, "events", 32'(slot_evt), 32'(e_ev));
    chk(tag, "flags", {28'd0, busy, inv_cmd, inv_mode, cmd_det}, {28'd0, 1'b0, m_ic, m_im, m_det});
  endtask

  task automatic model_slot(int s, logic [1:0] r, logic [1:0] p, logic [1:0] a);
    logic [1:0] cur = m_st[s];
    if (p != 0) m_pw[s] = p;
    if (a != 0) m_at[s] = a;
    if (cur == 3 && (r == 1 || r == 2)) m_st[s] = r;
    else if ((cur == 1 || cur == 2) && r == 3) begin
      m_st[s] = 3;
      if (m_pw[s] == 3) begin m_mrl[s] = 1; m_pr[s] = 3; m_ev[s] = 3'b111; end
    end
  endtask

  task automatic model_cmd(logic [7:0] c, logic [7:0] t);
    int tg = int'(t[4:0]);
    bit en = 0;
    m_ic = 0; m_im = 0; m_det = 1;
    if (c < 8'h40) begin
      if (tg == 0 || tg > N) m_ic = 1;
      else if (m_st[tg-1] == 2 && c[1:0] == 1) m_ic = 1;
      else model_slot(tg - 1, c[1:0], c[3:2], c[5:4]);
    end else if (c <= 8'h47) m_im = c[2:0] != 0;
    else if (c == 8'h48 || c == 8'h49) begin
      for (int i = 0; i < N; i++) if (m_st[i] == 2) en = 1;
      if (en) m_ic = 1;
      else for (int i = 0; i < N; i++)
        if (m_mrl[i]) model_slot(i, 0, 3, 0);
        else model_slot(i, (c == 8'h48) ? 2'd1 : 2'd2, 1, 0);
    end else m_ic = 1;
  endtask

  task automatic step(bit wr, logic [7:0] c, logic [7:0] t, logic [N-1:0] ec, bit dc, string tag);
    @(negedge clk);
    cmd_wr = wr; cmd_code = c; cmd_target = t; evt_clr = ec; det_clr = dc;
    for (int i = 0; i < N; i++) if (ec[i]) m_ev[i] = 0;
    if (!wr && dc) m_det = 0;
    if (wr) model_cmd(c, t);
    @(negedge clk);
    cmd_wr = 0; evt_clr = '0; det_clr = 0;
    check_all(tag);
  endtask

  task automatic do_reset(logic [N-1:0] occ);
    @(negedge clk);
    rst_n = 0; occupied = occ;
    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      m_st[i] = occ[i] ? 2'd2 : 2'd3; m_pw[i] = occ[i] ? 2'd1 : 2'd3;
      m_at[i] = 0; m_pr[i] = occ[i] ? 2'd0 : 2'd3; m_mrl[i] = !occ[i]; m_ev[i] = 0;
    end
    m_ic = 0; m_im = 0; m_det = 0;
    check_all("R1");
    rst_n = 1;
  endtask

  task automatic rand_run(int n);
    for (int k = 0; k < n; k++) begin
      int r = int'($urandom % 10);
      logic [N-1:0] ec = ($urandom % 5 == 0) ? N'($urandom) : '0;
      bit dc = ($urandom % 5 == 0);
      if (r < 6) step(1, 8'($urandom % 64), 8'($urandom % 8), ec, dc, "R2");
      else if (r == 6) step(1, 8'h40 + 8'($urandom % 8), 8'd0, ec, dc, "R7");
      else if (r == 7) step(1, 8'h48 + 8'($urandom % 2), 8'd0, ec, dc, "R8");
      else if (r == 8) step(1, 8'($urandom), 8'($urandom), ec, dc, "R9");
      else step(0, 8'd0, 8'd0, ec, dc, "R11");
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset(6'b100101);
    step(1, 8'h01, 8'd1, '0, 0, "R3");   // enabled -> power-only refused
    step(1, 8'h06, 8'd2, '0, 0, "R2");   // disabled -> enabled, power on
    step(1, 8'h20, 8'd2, '0, 0, "R4");   // attention blink only
    step(1, 8'h02, 8'd2, '0, 0, "R12");  // enabled -> enabled: no change
    step(1, 8'h0F, 8'd2, '0, 0, "R6");   // disable with power off: removal
    step(1, 8'h03, 8'd3, '0, 0, "R6");   // disable with power on: no removal
    step(1, 8'h06, 8'd0, '0, 0, "R5");
    step(1, 8'h06, 8'd7, '0, 0, "R5");
    step(1, 8'h40, 8'd0, '0, 0, "R7");
    step(1, 8'h43, 8'd0, '0, 0, "R7");
    step(1, 8'h49, 8'd0, '0, 0, "R8");   // refused: slots enabled
    step(1, 8'h03, 8'd1, '0, 0, "R8");
    step(1, 8'h03, 8'd6, '0, 0, "R8");
    step(1, 8'h48, 8'd0, '0, 0, "R8");   // power-only all
    step(1, 8'h4A, 8'd0, '0, 0, "R9");
    step(1, 8'hFF, 8'd3, '0, 0, "R9");
    step(1, 8'h00, 8'd1, '0, 0, "R10");  // flags cleared by valid command
    step(1, 8'h0F, 8'd1, 6'b000001, 0, "R11"); // removal set beats clear
    step(0, 8'h00, 8'd0, 6'b000011, 0, "R11");
    step(0, 8'h00, 8'd0, '0, 1, "R11");
    step(1, 8'h40, 8'd0, '0, 1, "R11");  // detect set beats clear
    rand_run(400);
    do_reset(6'b011011);
    rand_run(400);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule